// File: doc/BRIEF.md
# JTAG TAP Master Shift Engine

This block is a hardware JTAG master. It generates the test clock from the system clock, drives the mode-select and data-in lines, and samples the data-out line from the target. A host issues one command at a time on a small parallel interface. There are four commands: walk the target TAP into its reset state, hold it idle for a set number of test-clock cycles, load an instruction, or shift a data register while capturing what comes back.

Each command is a fixed mode-select walk. It starts and ends in Run-Test/Idle. For the two shift commands the data word goes out least significant bit first, and mode-select rises together with the last data bit. The captured target bits come back in the same order. When a command finishes, `done` pulses for one cycle. An illegal length is refused: `done` and `error` pulse together and the test clock never toggles.

Top module: `jtag_tap_master`

## Requirements
- R1: Command code 0 (TAP reset) produces six test-clock cycles: mode-select is 1 for the first five and 0 for the sixth.
- R2: An instruction load (code 2) enters with mode-select 1,1,0,0. A data shift (code 3) enters with mode-select 1,0,0.
- R3: In both shift commands, `cmdData` bit i is presented on `tdi` during shift cycle i, for the `cmdLen` shift cycles. Mode-select is 0 on every shift cycle except the last, where it is 1. Two exit cycles follow, with mode-select 1 then 0, which leaves the target in Run-Test/Idle.
- R4: During a shift command, `tdo` is sampled once per shift cycle. The bit from cycle i lands in `rxData[i]`. Every bit of `rxData` at or above `cmdLen` reads 0.
- R5: An idle command (code 1) produces exactly `cmdLen` test-clock cycles with mode-select 0. Any count from 1 to 2^LEN_W-1 is accepted.
- R6: A command is refused when any of these holds: it is an idle, instruction or data command with `cmdLen` of 0; it is an instruction load longer than IR_MAX; or it is a data shift longer than DATA_W. A refused command raises `done` and `error` for one cycle and produces no test-clock edge.
- R7: `tck` rests low while the block is not busy. Each high and low phase of `tck` lasts HALF_DIV system clocks. `tms` and `tdi` change only as `tck` falls, and `tdo` is sampled as `tck` rises.
- R8: A command is taken only when `cmdValid` is high while `busy` is low. A `cmdValid` pulse that arrives while `busy` is high is ignored.
- R9: `done` is a single-cycle pulse at the end of a command, with `busy` already low. `rxData` is valid at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 0 reset, 1 idle, 2 instruction load, 3 data shift |
| cmdLen | input | LEN_W | Bit count for shifts, or cycle count for idle |
| cmdData | input | DATA_W | Shift-out word, least significant bit first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Pulses with `done` when a command is refused |
| rxData | output | DATA_W | Captured target bits, bit i from shift cycle i |
| tck | output | 1 | Test clock |
| tms | output | 1 | Mode select |
| tdi | output | 1 | Data to target |
| tdo | input | 1 | Data from target |

## Verification
The bench builds the block with HALF_DIV of 2, DATA_W of 32, IR_MAX of 32 and LEN_W of 16. The short divider keeps a 10000-cycle idle run to about 40000 system clocks, so the large end of the idle range fits in the run. With IR_MAX equal to DATA_W, both shift kinds can be exercised at their full 32-bit length, and rejected one bit past it.

A model of the 16-state TAP controller sits on the pins. It confirms that the target lands in Run-Test/Idle, and it records the instruction and data bits the target actually received.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IDLE  = 2'd1,
    OP_IR    = 2'd2,
    OP_DR    = 2'd3
  } jtmOp_e;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic present;  // drive the next step's pin values
    logic tmsVal;   // mode-select value of that step
    logic useData;  // step is a shift step: tdi from the tx word, capture tdo
    logic loadTx;   // new command: load tx word, clear capture
  } jtmStrobe_t;

endpackage

// File: rtl/jtm_datapath.sv
module jtm_datapath
  import jtm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  jtmStrobe_t        strb,
  input  logic              run,
  input  logic [DATA_W-1:0] txData,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              riseEv,
  output logic              fallEv,
  output logic [DATA_W-1:0] rxData
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [DATA_W-1:0] txSr;
  logic [IDX_W-1:0]  rxIdx;
  logic              capArm;
  logic              term;

  assign term   = run && (divCnt == DIV_LAST);
  assign riseEv = term && !tck;
  assign fallEv = term && tck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      tck    <= 1'b0;
      tms    <= 1'b0;
      tdi    <= 1'b0;
      capArm <= 1'b0;
      txSr   <= '0;
      rxIdx  <= '0;
      rxData <= '0;
    end else begin
      if (strb.loadTx)   divCnt <= '0;
      else if (run)      divCnt <= term ? '0 : divCnt + DIV_W'(1);
      if (term)          tck <= ~tck;
      if (strb.present) begin
        tms    <= strb.tmsVal;
        tdi    <= strb.useData & txSr[0];
        capArm <= strb.useData;
      end
      if (strb.loadTx)                       txSr <= txData;
      else if (strb.present && strb.useData) txSr <= txSr >> 1;
      if (strb.loadTx) begin
        rxData <= '0;
        rxIdx  <= '0;
      end else if (riseEv && capArm) begin
        rxData[rxIdx] <= tdo;
        rxIdx         <= rxIdx + IDX_W'(1);
      end
    end
  end

  // R7: pin values move only while the test clock is low
  p_tms_moves_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tms) |-> !tck);
  p_tdi_moves_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tdi) |-> !tck);

endmodule

// File: rtl/jtm_control.sv
module jtm_control
  import jtm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int IR_MAX = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             fallEv,
  output jtmStrobe_t       strb,
  output logic             busy,
  output logic             done,
  output logic             error
);

  typedef enum logic [2:0] {PH_IDLE, PH_RST, PH_ENTRY, PH_SHIFT, PH_WAIT, PH_EXIT} phase_e;

  phase_e           phase, nextPhase, startPhase;
  logic [LEN_W-1:0] cnt, nextCnt, lastIdx, lenR;
  jtmOp_e           opR, opIn;
  logic             accept, cmdOk, isLast;

  function automatic logic tmsFor(phase_e ph, logic [LEN_W-1:0] c, jtmOp_e op,
                                  logic [LEN_W-1:0] len);
    case (ph)
      PH_RST:   return c < LEN_W'(5);
      PH_ENTRY: return (op == OP_IR) ? (c < LEN_W'(2)) : (c == '0);
      PH_SHIFT: return c == len - LEN_W'(1);
      PH_EXIT:  return c == '0;
      default:  return 1'b0;
    endcase
  endfunction

  assign opIn   = jtmOp_e'(cmdOp);
  assign accept = (phase == PH_IDLE) && cmdValid;
  assign busy   = (phase != PH_IDLE);

  always_comb begin
    case (opIn)
      OP_RESET: begin cmdOk = 1'b1;                                   startPhase = PH_RST;   end
      OP_IDLE:  begin cmdOk = (cmdLen != '0);                         startPhase = PH_WAIT;  end
      OP_IR:    begin cmdOk = (cmdLen != '0) && (cmdLen <= LEN_W'(IR_MAX)); startPhase = PH_ENTRY; end
      default:  begin cmdOk = (cmdLen != '0) && (cmdLen <= LEN_W'(DATA_W)); startPhase = PH_ENTRY; end
    endcase
  end

  always_comb begin
    case (phase)
      PH_RST:            lastIdx = LEN_W'(5);
      PH_ENTRY:          lastIdx = (opR == OP_IR) ? LEN_W'(3) : LEN_W'(2);
      PH_SHIFT, PH_WAIT: lastIdx = lenR - LEN_W'(1);
      PH_EXIT:           lastIdx = LEN_W'(1);
      default:           lastIdx = '0;
    endcase
    isLast  = (cnt == lastIdx);
    nextCnt = isLast ? '0 : cnt + LEN_W'(1);
    if (!isLast) nextPhase = phase;
    else begin
      case (phase)
        PH_ENTRY: nextPhase = PH_SHIFT;
        PH_SHIFT: nextPhase = PH_EXIT;
        default:  nextPhase = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (accept && cmdOk) begin
      strb.present = 1'b1;
      strb.loadTx  = 1'b1;
      strb.tmsVal  = tmsFor(startPhase, '0, opIn, cmdLen);
    end else if (busy && fallEv && nextPhase != PH_IDLE) begin
      strb.present = 1'b1;
      strb.useData = (nextPhase == PH_SHIFT);
      strb.tmsVal  = tmsFor(nextPhase, nextCnt, opR, lenR);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      lenR  <= '0;
      opR   <= OP_RESET;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      if (accept) begin
        if (cmdOk) begin
          phase <= startPhase;
          cnt   <= '0;
          opR   <= opIn;
          lenR  <= cmdLen;
        end else begin
          done  <= 1'b1;
          error <= 1'b1;
        end
      end else if (busy && fallEv) begin
        phase <= nextPhase;
        cnt   <= nextCnt;
        if (nextPhase == PH_IDLE) done <= 1'b1;
      end
    end
  end

  // R6: a refusal is always reported as a completion
  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
  // R9: completion is only flagged once the sequencer is free
  p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/jtag_tap_master.sv
module jtag_tap_master
  import jtm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 16,
  parameter int IR_MAX   = 32,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rxData,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);

  jtmStrobe_t strb;
  logic       riseEv, fallEv;

  jtm_control #(.DATA_W(DATA_W), .LEN_W(LEN_W), .IR_MAX(IR_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .fallEv(fallEv), .strb(strb), .busy(busy), .done(done), .error(error)
  );

  jtm_datapath #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .run(busy), .txData(cmdData), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .riseEv(riseEv), .fallEv(fallEv), .rxData(rxData)
  );

  // R7: the test clock is parked low whenever no command runs
  p_tck_parked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

endmodule

// File: tb/tb_jtag_tap_master.sv
module tb_jtag_tap_master;

  localparam int HALF = 2;
  localparam logic [31:0] DR_CAP = 32'h9E37_79B9;

  typedef enum logic [3:0] {TLR, RTI, SELDR, CAPDR, SHDR, EX1DR, PAUDR, EX2DR, UPDR,
                            SELIR, CAPIR, SHIR, EX1IR, PAUIR, EX2IR, UPIR} tap_e;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = '0;
  logic [15:0] cmdLen = '0;
  logic [31:0] cmdData = '0;
  logic        busy, done, error, tck, tms, tdi;
  logic [31:0] rxData;
  logic        tdo = 1'b0;

  int testCnt = 0, failCnt = 0;

  always #2.5 clk = ~clk;

  jtag_tap_master #(.DATA_W(32), .LEN_W(16), .IR_MAX(32), .HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .cmdData(cmdData), .busy(busy), .done(done), .error(error), .rxData(rxData),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // ---------------- target TAP model ----------------
  tap_e        tapSt = PAUDR;
  logic [31:0] drSr = '0, irSr = '0;
  logic [63:0] drIn = '0, irIn = '0;
  int          drCnt = 0, irCnt = 0, totRises = 0, onesTot = 0;
  logic        tmsHist [0:255];

  function automatic tap_e tapNext(tap_e s, logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PAUDR;
      PAUDR: return m ? EX2DR : PAUDR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PAUIR;
      PAUIR: return m ? EX2IR : PAUIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    case (tapSt)
      CAPDR: begin drSr <= DR_CAP; drCnt <= 0; end
      SHDR:  begin drSr <= {tdi, drSr[31:1]}; drIn[drCnt] <= tdi; drCnt <= drCnt + 1; end
      CAPIR: begin irSr <= 32'h1; irCnt <= 0; end
      SHIR:  begin irSr <= {tdi, irSr[31:1]}; irIn[irCnt] <= tdi; irCnt <= irCnt + 1; end
      default: ;
    endcase
    tapSt <= tapNext(tapSt, tms);
    tmsHist[totRises % 256] <= tms;
    totRises <= totRises + 1;
    onesTot  <= onesTot + int'(tms);
  end

  always @(negedge tck)
    tdo <= (tapSt == SHDR) ? drSr[0] : (tapSt == SHIR) ? irSr[0] : 1'b0;

  // ---------------- pin timing monitor (R7) ----------------
  int   edgeViol = 0, hiChecks = 0, hiRun = 0;
  logic prevTms = 1'b0, prevTdi = 1'b0, prevTck = 1'b0;
  always @(negedge clk) if (rstN) begin
    if (tck && (tms !== prevTms)) edgeViol++;
    if (tck && (tdi !== prevTdi)) edgeViol++;
    if (!busy && tck) edgeViol++;
    if (tck) hiRun++;
    else if (prevTck) begin
      hiChecks++;
      if (hiRun != HALF) edgeViol++;
      hiRun = 0;
    end
    prevTms = tms; prevTdi = tdi; prevTck = tck;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input int op, input int len, input logic [31:0] data,
                        output logic gotErr, output int rises, output int startIdx);
    @(negedge clk);
    startIdx = totRises;
    cmdValid = 1'b1; cmdOp = op[1:0]; cmdLen = len[15:0]; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    gotErr = error;
    rises  = totRises - startIdx;
  endtask

  function automatic logic [63:0] getWalk(int startIdx, int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n && i < 64; i++) v[i] = tmsHist[(startIdx + i) % 256];
    return v;
  endfunction

  // expected mode-select walk for a command, from the requirements
  function automatic logic [63:0] expWalk(int op, int len, output int n);
    logic [63:0] v = '0;
    n = 0;
    if (op == 0) begin
      for (int i = 0; i < 6; i++) begin v[n] = (i < 5); n++; end
    end else if (op == 1) begin
      n = len;
    end else begin
      v[0] = 1'b1;
      if (op == 2) begin v[1] = 1'b1; n = 4; end else n = 3;
      n = n + len;
      v[n-1] = 1'b1;
      v[n]   = 1'b1;
      n = n + 2;
    end
    return v;
  endfunction

  function automatic logic [63:0] maskN(int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R7 reset tck", tck, 0);
    chk("R1 reset tms", tms, 0);
  endtask

  task automatic t_tap_reset();
    logic e; int r, s, n; logic [63:0] w;
    w = expWalk(0, 0, n);
    runCmd(0, 0, '0, e, r, s);
    chk("R1 reset cycles", r, n);
    chk("R1 reset walk", getWalk(s, r), w);
    chk("R1 target idle", tapSt, RTI);
    chk("R1 no error", e, 0);
  endtask

  task automatic t_ir_load(input int len, input logic [31:0] op);
    logic e; int r, s, n; logic [63:0] w;
    w = expWalk(2, len, n);
    runCmd(2, len, op, e, r, s);
    chk("R2 R3 ir cycles", r, n);
    chk("R2 R3 ir walk", getWalk(s, r), w);
    chk("R3 ir bits received", irIn & maskN(len), {32'h0, op} & maskN(len));
    chk("R3 ir target idle", tapSt, RTI);
  endtask

  task automatic t_dr_shift(input int len, input logic [31:0] data);
    logic e; int r, s, n; logic [63:0] w;
    w = expWalk(3, len, n);
    runCmd(3, len, data, e, r, s);
    chk("R2 R3 dr cycles", r, n);
    chk("R2 R3 dr walk", getWalk(s, r), w);
    chk("R3 dr bits received", drIn & maskN(len), {32'h0, data} & maskN(len));
    chk("R4 captured bits", {32'h0, rxData}, {32'h0, DR_CAP} & maskN(len));
    chk("R3 dr target idle", tapSt, RTI);
  endtask

  task automatic t_idle(input int len);
    logic e; int r, s, o;
    o = onesTot;
    runCmd(1, len, '0, e, r, s);
    chk("R5 idle cycles", r, len);
    chk("R5 idle tms low", onesTot - o, 0);
    chk("R5 idle keeps target", tapSt, RTI);
  endtask

  task automatic t_reject(input int op, input int len);
    logic e; int r, s;
    runCmd(op, len, 32'hFFFF_FFFF, e, r, s);
    chk("R6 error flag", e, 1);
    chk("R6 no tck edge", r, 0);
  endtask

  task automatic t_busy_ignore();
    logic e; int r, s, n; logic [63:0] w;
    w = expWalk(3, 8, n);
    @(negedge clk);
    s = totRises;
    cmdValid = 1'b1; cmdOp = 2'd3; cmdLen = 16'd8; cmdData = 32'h5A;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 busy while running", busy, 1);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdLen = 16'd0;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    e = error;
    r = totRises - s;
    chk("R8 only first command ran", r, n);
    chk("R8 walk of first command", getWalk(s, r), w);
    repeat (20) begin
      @(negedge clk);
      if (done || busy) e = 1'b1;
    end
    chk("R8 no late command", e, 0);
  endtask

  task automatic t_done_pulse();
    logic e; int r, s;
    runCmd(3, 4, 32'h9, e, r, s);
    chk("R9 busy low at done", busy, 0);
    chk("R9 data valid at done", rxData, DR_CAP & 32'hF);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_pin_timing();
    chk("R7 pin edge violations", edgeViol, 0);
    chk("R7 high phases seen", hiChecks > 100, 1);
  endtask

  // ---------------- sequence and watchdog ----------------
  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tap_reset();
    t_ir_load(6, 32'h2D);
    t_ir_load(32, 32'hDEAD_BEEF);
    t_ir_load(1, 32'h1);
    t_dr_shift(13, 32'h1ABC);
    t_dr_shift(1, 32'h1);
    t_dr_shift(32, 32'hC3A5_0F96);
    t_idle(1);
    t_idle(10000);
    t_reject(2, 0);
    t_reject(2, 33);
    t_reject(3, 33);
    t_reject(3, 0);
    t_reject(1, 0);
    t_busy_ignore();
    t_done_pulse();
    t_tap_reset();
    t_pin_timing();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule